// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block steers a simple load-store core into and out of its exception handlers. Every clock edge it samples seven exception request lines. It discards the interrupt requests that the current status word masks and grants the highest-priority request that is left. For the granted exception it saves the return address and the old status word in registers banked for the target mode. It then rewrites the status word for that mode and issues a one-cycle program-counter redirect to the exception's vector.

The block owns the processor status word. The datapath can overwrite the status word through a write port, for example to drop into User mode. A return command reverses an entry in one step. It reloads the program counter from the current mode's banked link register and restores the status word from that mode's banked saved copy. Decode, the datapath and the handlers themselves live elsewhere.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bits are reset=0, undefined instruction=1, supervisor call=2, instruction abort=3, data abort=4, IRQ=5, FIQ=6. At most one request is granted per cycle, in the order reset, data abort, FIQ, IRQ, instruction abort, undefined instruction, supervisor call.
- R2: The vector driven on an entry is 0x000 for reset, 0x004 for undefined instruction, 0x008 for supervisor call, 0x00C for instruction abort, 0x010 for data abort, 0x018 for IRQ and 0x01C for FIQ. Offset 0x014 is never driven as a vector.
- R3: Status bits [4:0] hold the mode: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011. An entry selects Supervisor for reset and supervisor call, Undefined for undefined instruction, Abort for both aborts, IRQ mode for IRQ and FIQ mode for FIQ.
- R4: An entry writes pc_i + 4 into the target mode's banked link register and writes the pre-entry status word into that mode's banked saved-status register. Each of the five exception modes has its own pair of these registers.
- R5: Every entry sets status bit 7 (IRQ disable). Reset and FIQ entries also set bit 6 (FIQ disable). All other entries leave bit 6 unchanged.
- R6: An IRQ request is ignored while bit 7 is set, and an FIQ request is ignored while bit 6 is set. A reset request is never masked.
- R7: A return command outside User mode loads pc_target_o from the current mode's link register and restores the status word from its saved copy, both in the same cycle.
- R8: A return command in User mode changes neither the status word nor the program counter.
- R9: A granted exception takes precedence over a return command, and a return command takes precedence over a status write.
- R10: After asynchronous reset the status word reads 0x000000D3 (Supervisor, both masks set) and no redirect is pending.
- R11: Inputs are sampled on the rising edge. The resulting redirect and status change appear after that same edge, and pc_load_o is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 7 | Exception request lines, one bit per source |
| ret_i | input | 1 | Exception-return command |
| pc_i | input | ADDR_W | Address of the current instruction |
| psr_wr_i | input | 1 | Datapath write strobe for the status word |
| psr_wdata_i | input | 32 | Status word value to write |
| psr_o | output | 32 | Current status word |
| pc_load_o | output | 1 | One-cycle program-counter redirect strobe |
| pc_target_o | output | ADDR_W | Redirect address (vector or return address) |

## Verification
The assertions assume that undefined-instruction and supervisor-call requests never arrive together from a real decoder, although the arbiter still orders them. They also assume that the datapath writes only the mode encodings listed in R3 into the status word. The stimulus writes only valid modes through the status port. It combines requests so that the nesting order stays known, with an FIQ taken inside an abort handler, and it unwinds every nested entry with return commands, so that each banked pair is read back through the return path.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_BANKS = 5;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int BANK_IW   = $clog2(NUM_BANKS);
  localparam int I_BIT     = 7;
  localparam int F_BIT     = 6;

  localparam int SRC_RESET = 0;
  localparam int SRC_UNDEF = 1;
  localparam int SRC_SVC   = 2;
  localparam int SRC_PABT  = 3;
  localparam int SRC_DABT  = 4;
  localparam int SRC_IRQ   = 5;
  localparam int SRC_FIQ   = 6;

  // highest priority first
  localparam int PRIO_ORDER [NUM_SRC] = '{SRC_RESET, SRC_DABT, SRC_FIQ, SRC_IRQ,
                                         SRC_PABT, SRC_UNDEF, SRC_SVC};

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  function automatic logic [MODE_W-1:0] mode_of(input logic [2:0] src);
    case (src)
      3'(SRC_UNDEF): mode_of = MODE_UND;
      3'(SRC_PABT),
      3'(SRC_DABT):  mode_of = MODE_ABT;
      3'(SRC_IRQ):   mode_of = MODE_IRQ;
      3'(SRC_FIQ):   mode_of = MODE_FIQ;
      default:       mode_of = MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vector_of(input logic [2:0] src);
    case (src)
      3'(SRC_UNDEF): vector_of = 8'h04;
      3'(SRC_SVC):   vector_of = 8'h08;
      3'(SRC_PABT):  vector_of = 8'h0C;
      3'(SRC_DABT):  vector_of = 8'h10;
      3'(SRC_IRQ):   vector_of = 8'h18;
      3'(SRC_FIQ):   vector_of = 8'h1C;
      default:       vector_of = 8'h00;
    endcase
  endfunction

  function automatic logic bank_valid(input logic [MODE_W-1:0] m);
    bank_valid = (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
                 (m == MODE_ABT) || (m == MODE_UND);
  endfunction

  function automatic logic [BANK_IW-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bank_of = BANK_IW'(0);
      MODE_IRQ: bank_of = BANK_IW'(1);
      MODE_ABT: bank_of = BANK_IW'(3);
      MODE_UND: bank_of = BANK_IW'(4);
      default:  bank_of = BANK_IW'(2);
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               i_mask_i,
  input  logic               f_mask_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               valid_o,
  output logic [2:0]         src_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    elig = req_i;
    elig[SRC_IRQ] = req_i[SRC_IRQ] & ~i_mask_i;
    elig[SRC_FIQ] = req_i[SRC_FIQ] & ~f_mask_i;
  end

  always_comb begin
    grant_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant_o == '0 && elig[PRIO_ORDER[k]]) grant_o[PRIO_ORDER[k]] = 1'b1;
    end
  end

  always_comb begin
    src_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (grant_o[s]) src_o = 3'(s);
    end
  end

  assign valid_o = |grant_o;
endmodule

// File: rtl/exc_bank_regs.sv
module exc_bank_regs
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [BANK_IW-1:0] widx_i,
  input  logic [ADDR_W-1:0]  lr_i,
  input  logic [PSR_W-1:0]   spsr_i,
  input  logic [BANK_IW-1:0] ridx_i,
  output logic [ADDR_W-1:0]  lr_o,
  output logic [PSR_W-1:0]   spsr_o
);
  logic [ADDR_W-1:0] lr_q   [NUM_BANKS];
  logic [PSR_W-1:0]  spsr_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lr_q[b]   <= '0;
        spsr_q[b] <= '0;
      end else if (we_i && widx_i == BANK_IW'(b)) begin
        lr_q[b]   <= lr_i;
        spsr_q[b] <= spsr_i;
      end
    end
  end

  always_comb begin
    lr_o   = '0;
    spsr_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ridx_i == BANK_IW'(b)) begin
        lr_o   = lr_q[b];
        spsr_o = spsr_q[b];
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  exc_req_i,
  input  logic                ret_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                psr_wr_i,
  input  logic [PSR_W-1:0]    psr_wdata_i,
  output logic [PSR_W-1:0]    psr_o,
  output logic                pc_load_o,
  output logic [ADDR_W-1:0]   pc_target_o
);
  logic [PSR_W-1:0]   psr_q;
  logic               pc_load_q;
  logic [ADDR_W-1:0]  pc_tgt_q;

  logic [NUM_SRC-1:0] grant;
  logic               take;
  logic [2:0]         src;
  logic [MODE_W-1:0]  tgt_mode;
  logic [MODE_W-1:0]  cur_mode;
  logic               ret_ok;
  logic [ADDR_W-1:0]  rd_lr;
  logic [PSR_W-1:0]   rd_spsr;

  exc_arbiter u_arb (
    .req_i    (exc_req_i),
    .i_mask_i (psr_q[I_BIT]),
    .f_mask_i (psr_q[F_BIT]),
    .grant_o  (grant),
    .valid_o  (take),
    .src_o    (src)
  );

  assign tgt_mode = mode_of(src);
  assign cur_mode = psr_q[MODE_W-1:0];
  // return only from a banked mode; User has no saved state
  assign ret_ok   = ret_i && bank_valid(cur_mode);

  exc_bank_regs #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (take),
    .widx_i (bank_of(tgt_mode)),
    .lr_i   (pc_i + ADDR_W'(INSTR_BYTES)),
    .spsr_i (psr_q),
    .ridx_i (bank_of(cur_mode)),
    .lr_o   (rd_lr),
    .spsr_o (rd_spsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psr_q     <= PSR_RESET;
      pc_load_q <= 1'b0;
      pc_tgt_q  <= '0;
    end else begin
      pc_load_q <= 1'b0;
      if (take) begin
        psr_q[MODE_W-1:0] <= tgt_mode;
        psr_q[I_BIT]      <= 1'b1;
        if (grant[SRC_FIQ] || grant[SRC_RESET]) psr_q[F_BIT] <= 1'b1;
        pc_load_q <= 1'b1;
        pc_tgt_q  <= ADDR_W'(vector_of(src));
      end else if (ret_ok) begin
        psr_q     <= rd_spsr;
        pc_load_q <= 1'b1;
        pc_tgt_q  <= rd_lr;
      end else if (psr_wr_i) begin
        psr_q <= psr_wdata_i;
      end
    end
  end

  assign psr_o       = psr_q;
  assign pc_load_o   = pc_load_q;
  assign pc_target_o = pc_tgt_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] exc_req_i,
  input logic               ret_i,
  input logic               psr_wr_i,
  input logic [PSR_W-1:0]   psr_o,
  input logic               pc_load_o,
  input logic [ADDR_W-1:0]  pc_target_o,
  input logic [NUM_SRC-1:0] grant_i
);
  a_r1_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  a_r6_reset_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i[SRC_RESET] |=> pc_load_o && pc_target_o == '0 &&
      psr_o[MODE_W-1:0] == MODE_SVC && psr_o[I_BIT] && psr_o[F_BIT]);

  a_r6_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i == NUM_SRC'(1 << SRC_IRQ) && psr_o[I_BIT] && !ret_i) |=> !pc_load_o);

  a_r5_entry_sets_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exc_req_i[SRC_DABT:SRC_RESET]) |=> pc_load_o && psr_o[I_BIT]);

  a_r8_user_ret_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && psr_o[MODE_W-1:0] == MODE_USR && exc_req_i == '0 && !psr_wr_i)
      |=> !pc_load_o && $stable(psr_o));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_req_i   (exc_req_i),
  .ret_i       (ret_i),
  .psr_wr_i    (psr_wr_i),
  .psr_o       (psr_o),
  .pc_load_o   (pc_load_o),
  .pc_target_o (pc_target_o),
  .grant_i     (grant)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req = '0;
  logic        ret = 1'b0;
  logic [31:0] pc = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] psr;
  logic        load;
  logic [31:0] tgt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .ret_i(ret), .pc_i(pc),
    .psr_wr_i(wr), .psr_wdata_i(wdata), .psr_o(psr), .pc_load_o(load),
    .pc_target_o(tgt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive for one edge, then sample at the following falling edge
  task automatic step(input logic [6:0] r, input logic rt, input logic w,
                      input logic [31:0] wd, input logic [31:0] p);
    req = r; ret = rt; wr = w; wdata = wd; pc = p;
    @(negedge clk);
    req = '0; ret = 1'b0; wr = 1'b0;
  endtask

  task automatic expect_redirect(input string tag, input logic [31:0] t, input logic [31:0] s);
    chk({tag, " load"}, 32'(load), 32'd1);
    chk({tag, " target"}, tgt, t);
    chk({tag, " psr"}, psr, s);
  endtask

  task automatic expect_none(input string tag, input logic [31:0] s);
    chk({tag, " load"}, 32'(load), 32'd0);
    chk({tag, " psr"}, psr, s);
  endtask

  task automatic t_reset_state;
    expect_none("R10 reset", 32'hD3);
  endtask

  task automatic t_svc_return;
    step(7'h00, 0, 1, 32'h10, 0);           expect_none("R9 psr write", 32'h10);
    step(7'h04, 0, 0, 0, 32'h100);          expect_redirect("R2 R3 svc entry", 32'h08, 32'h93);
    step(7'h00, 0, 0, 0, 0);                expect_none("R11 single pulse", 32'h93);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R7 R4 svc return", 32'h104, 32'h10);
    step(7'h00, 1, 0, 0, 0);                expect_none("R8 user return", 32'h10);
  endtask

  task automatic t_priority;
    step(7'h7F, 0, 0, 0, 32'h200);          expect_redirect("R1 reset first", 32'h00, 32'hD3);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R4 reset saves", 32'h204, 32'h10);
    step(7'h7A, 0, 0, 0, 32'h300);          expect_redirect("R1 dabt over fiq", 32'h10, 32'h97);
    step(7'h68, 0, 0, 0, 32'h400);          expect_redirect("R1 fiq over irq", 32'h1C, 32'hD1);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R4 fiq bank", 32'h404, 32'h97);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R4 abort bank", 32'h304, 32'h10);
  endtask

  task automatic t_masking;
    step(7'h00, 0, 1, 32'h90, 0);           expect_none("R6 set I", 32'h90);
    step(7'h20, 0, 0, 0, 32'h500);          expect_none("R6 irq masked", 32'h90);
    step(7'h40, 0, 0, 0, 32'h500);          expect_redirect("R5 fiq sets F", 32'h1C, 32'hD1);
    step(7'h00, 0, 1, 32'h50, 0);           expect_none("R6 set F", 32'h50);
    step(7'h40, 0, 0, 0, 32'h550);          expect_none("R6 fiq masked", 32'h50);
    step(7'h20, 0, 0, 0, 32'h600);          expect_redirect("R5 irq keeps F", 32'h18, 32'hD2);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R7 irq return", 32'h604, 32'h50);
    step(7'h00, 0, 1, 32'hD0, 0);           expect_none("R6 all masked", 32'hD0);
    step(7'h01, 0, 0, 0, 32'h650);          expect_redirect("R6 reset unmasked", 32'h00, 32'hD3);
  endtask

  task automatic t_low_prio;
    step(7'h00, 0, 1, 32'h10, 0);           expect_none("R3 back to user", 32'h10);
    step(7'h06, 0, 0, 0, 32'h700);          expect_redirect("R1 undef over svc", 32'h04, 32'h9B);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R4 undef bank", 32'h704, 32'h10);
    step(7'h08, 0, 0, 0, 32'h800);          expect_redirect("R2 pabt vector", 32'h0C, 32'h97);
  endtask

  task automatic t_precedence;
    step(7'h04, 1, 0, 0, 32'h900);          expect_redirect("R9 entry over return", 32'h08, 32'h93);
    step(7'h00, 1, 1, 32'h10, 0);           expect_redirect("R9 return over write", 32'h904, 32'h97);
    step(7'h00, 1, 0, 0, 0);                expect_redirect("R7 abort return", 32'h804, 32'h10);
    step(7'h00, 0, 0, 0, 0);                expect_none("R11 idle", 32'h10);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_svc_return();
    t_priority();
    t_masking();
    t_low_prio();
    t_precedence();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule